// File: doc/BRIEF.md
# PLL Output Gating Controller

This block sits next to a phase-locked loop and decides, cycle by cycle, whether the PLL output clock may be forwarded to the logic that uses it. It watches three status inputs from the PLL: enable, startup complete and lock. It combines them with two policy bits held in its control register. A lock-bypass bit lets the clock run without lock. A fast-wake bit lets the clock start as soon as startup completes, without waiting for the first lock. The result is a registered clock-enable for the output gate.

The block also watches for a PLL that never locks. A free-running millisecond tick drives a counter that runs while the PLL is enabled and unlocked. When the count reaches the limit chosen by a lock-time code, a sticky timeout flag is raised. The control register also carries divider, low-power and filter fields. These fields are stored and read back but have no effect inside this block. The register can be write-protected, and while the PLL runs it accepts only the lock-bypass bit. The reference-select field is also sent out on its own port.

Top module: `pll_gate_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, the clock-enable and timeout flag are low and the reference index is 0. Field positions are: divider 26:16, lock bypass 12, lock-time code 10:8, reference select 5:4, fast wake 3, low-power 2, filter 1:0. Every other bit reads 0.
- R2: While `wr_lock` is high, a write leaves the control word unchanged.
- R3: While `pll_enable` is high, an accepted write changes only bit 12 (lock bypass). Every other field keeps its value.
- R4: A write with reference code 3 keeps the previous reference code and writes all other fields. Codes 0 to 2 are stored, and `ref_sel` always equals bits 5:4.
- R5: With lock bypass at 0, `clk_gate_en` is high one cycle after a cycle in which enable, startup-complete and lock are all high. In any other case it is low.
- R6: With lock bypass and fast wake both at 1, `clk_gate_en` follows enable and startup-complete one cycle later, whatever the lock input does.
- R7: With lock bypass at 1 and fast wake at 0, the clock stays gated until lock has been seen at least once since enable rose. After that, the enable follows enable and startup-complete alone, even if lock drops.
- R8: One cycle after `pll_enable` is low, `clk_gate_en` is low.
- R9: Lock-time codes 4, 5, 6 and 7 raise `timeout_flag` on the 8th, 9th, 10th and 11th millisecond tick counted while the PLL is enabled and unlocked. The flag is seen one cycle after that tick.
- R10: Lock-time code 0 and the reserved codes 1 to 3 never raise the timeout flag.
- R11: The tick count returns to zero whenever lock is high or the PLL is disabled.
- R12: The timeout flag stays high until `timeout_clr` is pulsed. If a new timeout and a clear fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_lock | input | 1 | Write protection active |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| pll_enable | input | 1 | PLL enabled |
| startup_done | input | 1 | PLL startup time complete |
| lock_in | input | 1 | PLL lock indication |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| timeout_clr | input | 1 | Clear pulse for the timeout flag |
| clk_gate_en | output | 1 | Enable for the PLL output clock gate |
| timeout_flag | output | 1 | Sticky lock-timeout flag |
| ref_sel | output | 2 | Selected reference source index |

## Verification
The bench walks every mix of bypass and fast wake against enable, startup and lock. This catches a gate that ignores lock in normal mode, or one that waits for lock when it should not. A separate sequence drops lock after the first lock with bypass set: a design with no memory of the first lock would close the gate there. The timeout limits are probed one tick before and at the limit for the shortest and longest codes, to expose an off-by-one counter. A reserved code that still times out is also caught. Further sequences interrupt counting with lock or disable, and fire a clear in the same cycle as a new timeout. A counter that is not cleared, or a clear that wins that cycle, shows up as a flag at the wrong tick.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int DATA_W   = 32;
    localparam int DIV_W    = 11;
    localparam int DIV_LSB  = 16;
    localparam int BYP_BIT  = 12;
    localparam int LT_W     = 3;
    localparam int LT_LSB   = 8;
    localparam int REF_W    = 2;
    localparam int REF_LSB  = 4;
    localparam int FAST_BIT = 3;
    localparam int LP_BIT   = 2;
    localparam int FLT_W    = 2;
    localparam int FLT_LSB  = 0;

    localparam logic [REF_W-1:0] REF_RESERVED = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bypass;
        logic [LT_W-1:0]  ltime;
        logic [REF_W-1:0] refsel;
        logic             fast;
        logic             lowpwr;
        logic [FLT_W-1:0] filt;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_LSB +: DIV_W] = c.div;
        w[BYP_BIT]          = c.bypass;
        w[LT_LSB +: LT_W]   = c.ltime;
        w[REF_LSB +: REF_W] = c.refsel;
        w[FAST_BIT]         = c.fast;
        w[LP_BIT]           = c.lowpwr;
        w[FLT_LSB +: FLT_W] = c.filt;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.div    = w[DIV_LSB +: DIV_W];
        c.bypass = w[BYP_BIT];
        c.ltime  = w[LT_LSB +: LT_W];
        c.refsel = w[REF_LSB +: REF_W];
        c.fast   = w[FAST_BIT];
        c.lowpwr = w[LP_BIT];
        c.filt   = w[FLT_LSB +: FLT_W];
        return c;
    endfunction

endpackage

// File: rtl/pgc_ctrl_reg.sv
module pgc_ctrl_reg
    import pgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pll_enable,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        ctrl_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        ctrl_t incoming;
        st_d     = st_q;
        incoming = word_to_ctrl(wr_data);
        if (wr_en && !wr_lock) begin
            if (pll_enable) begin
                // running PLL: only the bypass policy may change
                st_d.ctrl.bypass = incoming.bypass;
            end else begin
                st_d.ctrl = incoming;
                if (incoming.refsel == REF_RESERVED) begin
                    st_d.ctrl.refsel = st_q.ctrl.refsel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/pgc_timeout.sv
module pgc_timeout
    import pgc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pll_enable,
    input  logic            lock_in,
    input  logic            ms_tick,
    input  logic            timeout_clr,
    input  logic [LT_W-1:0] ltime,
    output logic            timeout_flag
);

    // codes with the top bit set map to 8 + low bits; the rest disable timing
    localparam logic [LT_W-1:0] LT_FIRST_VALID = LT_W'(1 << (LT_W - 1));
    localparam logic [CNT_W-1:0] LT_OFFSET     = CNT_W'(1 << (LT_W - 1));

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } to_state_t;

    to_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             armed;

    always_comb begin
        if (ltime >= LT_FIRST_VALID) begin
            limit = CNT_W'(ltime) + LT_OFFSET;
            armed = 1'b1;
        end else begin
            limit = '0;
            armed = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (timeout_clr) begin
            st_d.flag = 1'b0;
        end
        if (!pll_enable || lock_in) begin
            st_d.cnt = '0;
        end else if (ms_tick && armed && !st_q.flag) begin
            if (st_q.cnt + CNT_W'(1) == limit) begin
                st_d.flag = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout_flag = st_q.flag;

endmodule

// File: rtl/pgc_gate.sv
module pgc_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_enable,
    input  logic startup_done,
    input  logic lock_in,
    input  logic bypass,
    input  logic fast,
    output logic gate_en
);

    typedef struct packed {
        logic gate;
        logic seen_lock;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        logic ready;
        st_d = st_q;
        if (!pll_enable) begin
            st_d.seen_lock = 1'b0;
        end else if (lock_in) begin
            st_d.seen_lock = 1'b1;
        end

        if (!bypass) begin
            ready = lock_in;
        end else if (fast) begin
            ready = 1'b1;
        end else begin
            ready = st_q.seen_lock || lock_in;
        end
        st_d.gate = pll_enable && startup_done && ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_en = st_q.gate;

endmodule

// File: rtl/pll_gate_ctrl.sv
module pll_gate_ctrl
    import pgc_pkg::*;
#(
    parameter int TO_CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pll_enable,
    input  logic              startup_done,
    input  logic              lock_in,
    input  logic              ms_tick,
    input  logic              timeout_clr,
    output logic              clk_gate_en,
    output logic              timeout_flag,
    output logic [REF_W-1:0]  ref_sel
);

    ctrl_t ctrl;

    pgc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_lock    (wr_lock),
        .wr_data    (wr_data),
        .pll_enable (pll_enable),
        .ctrl_o     (ctrl)
    );

    pgc_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_enable   (pll_enable),
        .startup_done (startup_done),
        .lock_in      (lock_in),
        .bypass       (ctrl.bypass),
        .fast         (ctrl.fast),
        .gate_en      (clk_gate_en)
    );

    pgc_timeout #(
        .CNT_W (TO_CNT_W)
    ) u_to (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_enable   (pll_enable),
        .lock_in      (lock_in),
        .ms_tick      (ms_tick),
        .timeout_clr  (timeout_clr),
        .ltime        (ctrl.ltime),
        .timeout_flag (timeout_flag)
    );

    assign rd_data = ctrl_to_word(ctrl);
    assign ref_sel = ctrl.refsel;

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
    import pgc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_lock,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              pll_enable,
    input logic              startup_done,
    input logic              lock_in,
    input logic              ms_tick,
    input logic              timeout_clr,
    input logic              clk_gate_en,
    input logic              timeout_flag,
    input logic [REF_W-1:0]  ref_sel
);

    localparam logic [DATA_W-1:0] USED_MASK = 32'h07FF_173F;
    localparam logic [DATA_W-1:0] BYP_MASK  = DATA_W'(1) << BYP_BIT;

    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED_MASK) == '0);

    p_protect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> $stable(rd_data));

    p_running_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_enable |=> $stable(rd_data & ~BYP_MASK));

    p_ref_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel != REF_RESERVED && ref_sel == rd_data[REF_LSB +: REF_W]);

    p_unlocked_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[BYP_BIT] && !lock_in) |=> !clk_gate_en);

    p_no_startup_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !startup_done |=> !clk_gate_en);

    p_fast_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BYP_BIT] && rd_data[FAST_BIT] && pll_enable && startup_done)
        |=> clk_gate_en);

    p_disable_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_enable |=> !clk_gate_en);

    p_no_timeout_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[LT_LSB + LT_W - 1] && !timeout_flag) |=> !timeout_flag);

    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !timeout_clr) |=> timeout_flag);

endmodule

bind pll_gate_ctrl pgc_checker u_chk (.*);

// File: tb/pll_gate_ctrl_tb.sv
module pll_gate_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_lock = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pll_enable = 1'b0;
    logic        startup_done = 1'b0;
    logic        lock_in = 1'b0;
    logic        ms_tick = 1'b0;
    logic        timeout_clr = 1'b0;
    logic        clk_gate_en;
    logic        timeout_flag;
    logic [1:0]  ref_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pll_gate_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_lock      (wr_lock),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .pll_enable   (pll_enable),
        .startup_done (startup_done),
        .lock_in      (lock_in),
        .ms_tick      (ms_tick),
        .timeout_clr  (timeout_clr),
        .clk_gate_en  (clk_gate_en),
        .timeout_flag (timeout_flag),
        .ref_sel      (ref_sel)
    );

    // {bypass, fast, enable, startup, lock, expected gate}
    localparam int NVEC = 11;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00111_1, 6'b00110_0, 6'b00101_0, 6'b00011_0,
        6'b01110_0, 6'b01111_1, 6'b11110_1, 6'b11100_0,
        6'b10110_0, 6'b10111_1, 6'b11011_0
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write(logic [31:0] d, logic prot);
        @(negedge clk);
        wr_data = d;
        wr_lock = prot;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_lock = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_flag();
        timeout_clr = 1'b1;
        @(negedge clk);
        timeout_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset gate", {31'b0, clk_gate_en}, 32'h0);
        check("R1 reset flag", {31'b0, timeout_flag}, 32'h0);
        check("R1 reset ref", {30'b0, ref_sel}, 32'h0);

        // R1 / R4: all ones, reference code 3 keeps the old code 0
        write(32'hFFFF_FFFF, 1'b0);
        check("R1 layout readback", rd_data, 32'h07FF_170F);
        write(32'h0000_0020, 1'b0);
        check("R4 ref code 2", {30'b0, ref_sel}, 32'h2);
        write(32'h0000_0130, 1'b0);
        check("R4 reserved ref held", rd_data, 32'h0000_0120);
        // R2 protected write ignored
        write(32'h0000_0000, 1'b1);
        check("R2 protected write", rd_data, 32'h0000_0120);
        // R3 running write: only bypass changes
        pll_enable = 1'b1;
        write(32'hFFFF_FFFF, 1'b0);
        check("R3 running write", rd_data, 32'h0000_1120);
        write(32'h0000_0000, 1'b0);
        check("R3 running bypass clear", rd_data, 32'h0000_0120);
        pll_enable = 1'b0;

        // table walk over the gating policy (R5, R6, R7, R8)
        for (int v = 0; v < NVEC; v++) begin
            pll_enable = 1'b0; startup_done = 1'b0; lock_in = 1'b0;
            write({19'b0, VEC[v][5], 8'b0, VEC[v][4], 3'b0}, 1'b0);
            pll_enable   = VEC[v][3];
            startup_done = VEC[v][2];
            lock_in      = VEC[v][1];
            @(negedge clk);
            check($sformatf("R5/R6/R7/R8 gate vector %0d", v),
                  {31'b0, clk_gate_en}, {31'b0, VEC[v][0]});
        end

        // R7: first lock opens the gate, later loss of lock does not close it
        pll_enable = 1'b0; startup_done = 1'b0; lock_in = 1'b0;
        write(32'h0000_1000, 1'b0);
        pll_enable = 1'b1; startup_done = 1'b1;
        @(negedge clk);
        check("R7 before lock", {31'b0, clk_gate_en}, 32'h0);
        lock_in = 1'b1;
        @(negedge clk);
        check("R7 at lock", {31'b0, clk_gate_en}, 32'h1);
        lock_in = 1'b0;
        @(negedge clk);
        check("R7 after lock lost", {31'b0, clk_gate_en}, 32'h1);
        pll_enable = 1'b0;
        @(negedge clk);
        check("R8 disable closes gate", {31'b0, clk_gate_en}, 32'h0);
        startup_done = 1'b0;

        // R9: code 4 -> 8 ticks
        write(32'h0000_0400, 1'b0);
        pll_enable = 1'b1;
        ticks(7);
        check("R9 code4 tick7", {31'b0, timeout_flag}, 32'h0);
        ticks(1);
        check("R9 code4 tick8", {31'b0, timeout_flag}, 32'h1);
        // R12 sticky through lock, then cleared
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        @(negedge clk);
        check("R12 sticky", {31'b0, timeout_flag}, 32'h1);
        clear_flag();
        check("R12 clear", {31'b0, timeout_flag}, 32'h0);
        // R12 set beats clear in the same cycle
        ticks(7);
        ms_tick = 1'b1; timeout_clr = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0; timeout_clr = 1'b0;
        check("R12 set wins over clear", {31'b0, timeout_flag}, 32'h1);
        clear_flag();

        // R9: code 7 -> 11 ticks
        pll_enable = 1'b0;
        write(32'h0000_0700, 1'b0);
        pll_enable = 1'b1;
        ticks(10);
        check("R9 code7 tick10", {31'b0, timeout_flag}, 32'h0);
        ticks(1);
        check("R9 code7 tick11", {31'b0, timeout_flag}, 32'h1);
        clear_flag();

        // R10: code 0 and reserved code 2
        pll_enable = 1'b0;
        write(32'h0000_0000, 1'b0);
        pll_enable = 1'b1;
        ticks(20);
        check("R10 code0 no timeout", {31'b0, timeout_flag}, 32'h0);
        pll_enable = 1'b0;
        write(32'h0000_0200, 1'b0);
        pll_enable = 1'b1;
        ticks(20);
        check("R10 reserved code2 no timeout", {31'b0, timeout_flag}, 32'h0);

        // R11: lock restarts the count
        pll_enable = 1'b0;
        write(32'h0000_0400, 1'b0);
        pll_enable = 1'b1;
        ticks(5);
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        ticks(7);
        check("R11 lock restarts count", {31'b0, timeout_flag}, 32'h0);
        ticks(1);
        check("R11 full count after lock", {31'b0, timeout_flag}, 32'h1);
        clear_flag();
        // R11: disable restarts the count
        ticks(5);
        pll_enable = 1'b0;
        @(negedge clk);
        pll_enable = 1'b1;
        ticks(7);
        check("R11 disable restarts count", {31'b0, timeout_flag}, 32'h0);
        ticks(1);
        check("R11 full count after disable", {31'b0, timeout_flag}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule